// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands, a multiplicand `x_in` of `X_W` bits and a multiplier `y_in` of `Y_W` bits, and returns their full `X_W+Y_W`-bit product. Every pair of operand bits is combined by an AND gate to form a partial-product bit. These bits are then reduced in a rectangular array of adder cells. Both operands are fanned out to every cell of the array.

Inside the array no carry travels sideways along a row. Each cell hands its carry down to the cell of the next row that has the same weight. The array therefore ends with one sum vector and one carry vector. The first reduction row uses half adders and the later rows use full adders. One low product bit leaves the array at each row. A ripple adder, with its carry input tied to zero, joins the final sum and carry vectors into the upper product bits.

The combined product is captured in an output register that has a synchronous active-low reset. The result therefore appears one clock after the operands are presented. The default size is 4x4 with an 8-bit product.

Top module: `csa_mult`

## Requirements
- R1: One clock edge after the operands are sampled with `rst_n` high, `z_out` equals the unsigned product `x_in * y_in`, zero-extended to `X_W+Y_W` bits.
- R2: Each partial-product bit is `x_in[i] AND y_in[j]` with weight 2^(i+j). With single-bit operands `x_in = 1<<i` and `y_in = 1<<j`, `z_out` is `1<<(i+j)`.
- R3: The low `Y_W` product bits come out of the reduction rows, one per row, and equal `(x_in*y_in) mod 2^Y_W`.
- R4: The vector-merging adder uses a carry input of 0 and never produces a carry out of bit `X_W+Y_W-1`. Products with the top bit set (for example 15*9 = 135 at 4x4) are exact.
- R5: While `rst_n` is low at a rising clock edge, `z_out` becomes 0, whatever the operand values.
- R6: If either operand is zero, `z_out` is 0 one edge later.
- R7: All-ones operands give `(2^X_W-1)*(2^Y_W-1)`, which is 225 at 4x4.
- R8: The widths follow the parameters. At 6x4, 42*11 gives 462 (binary 111001110).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset of the product register |
| x_in | input | X_W | Unsigned multiplicand |
| y_in | input | Y_W | Unsigned multiplier |
| z_out | output | X_W+Y_W | Registered unsigned product |

## Verification
On every cycle, the assertions check:
- the registered product against a reference multiplication of the previous operands;
- the low bits leaving the array rows against the same reference;
- that the merging adder never carries out;
- that reset clears the output;
- that a zero operand yields zero.

Only the bench's scenarios show:
- that all 256 operand pairs at 4x4 give exact results;
- that single-bit operands land at the right weight;
- that a reset asserted in mid-run overrides live operands;
- that the 6x4 instance reproduces the worked 42*11 case.

// File: rtl/csa_mult_pkg.sv
// Package: shared types for the carry-save array multiplier.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package csa_mult_pkg;

    // Result of one adder cell: a sum bit of the cell's own weight and a
    // carry bit of the next higher weight.
    typedef struct packed {
        logic carry;
        logic sum;
    } cs_bit_t;

endpackage

// File: rtl/csa_cell.sv
// Module: csa_cell
// One adder cell of the array or of the merging adder. FULL=1 builds a
// full adder over a, b and cin; FULL=0 builds a half adder over a and b.
// Assumes: in the half-adder variant the caller ties cin to a constant.
module csa_cell
    import csa_mult_pkg::*;
#(
    parameter bit FULL = 1'b1
) (
    input  logic    a,
    input  logic    b,
    input  logic    cin,
    output cs_bit_t res
);

    generate
        if (FULL) begin : g_full
            // Three-input add: sum is the parity, carry is the majority.
            always_comb begin
                res.sum   = a ^ b ^ cin;
                res.carry = (a & b) | (cin & (a ^ b));
            end
        end else begin : g_half
            logic unused_cin;
            assign unused_cin = cin;
            // Two-input add: no third operand exists in the first row.
            always_comb begin
                res.sum   = a ^ b;
                res.carry = a & b;
            end
        end
    endgenerate

endmodule

// File: rtl/csa_pp_gen.sv
// Module: csa_pp_gen
// Forms every partial-product bit as the AND of one multiplicand bit and
// one multiplier bit. Row j holds x AND y[j], weight j+i for column i.
// Assumes: operands are unsigned.
module csa_pp_gen #(
    parameter int X_W = 4,
    parameter int Y_W = 4
) (
    input  logic [X_W-1:0]            x_op,
    input  logic [Y_W-1:0]            y_op,
    output logic [Y_W-1:0][X_W-1:0]   pp
);

    generate
        for (genvar j = 0; j < Y_W; j++) begin : g_row
            for (genvar i = 0; i < X_W; i++) begin : g_col
                // Single AND gate for partial-product bit (i, j).
                assign pp[j][i] = x_op[i] & y_op[j];
            end
        end
    endgenerate

endmodule

// File: rtl/csa_array.sv
// Module: csa_array
// Carry-save reduction of the partial-product rows. Row 0 is taken as is;
// each later row j adds its partial products to the previous sum vector
// (shifted down by one column) and to the previous carry vector, without
// any sideways carry. Row 1 uses half adders, rows 2 and up full adders.
// Column 0 of each row leaves as one low product bit.
// Assumes: X_W >= 2 and Y_W >= 2.
module csa_array
    import csa_mult_pkg::*;
#(
    parameter int X_W = 4,
    parameter int Y_W = 4
) (
    input  logic [Y_W-1:0][X_W-1:0] pp,
    output logic [Y_W-1:0]          low_bits,
    output logic [X_W-2:0]          sum_rem,
    output logic [X_W-1:0]          car_rem
);

    localparam int LAST = Y_W - 1;

    logic [Y_W-1:0][X_W-1:0] sum_v;
    logic [Y_W-1:0][X_W-1:0] car_v;

    // Row 0 is the first partial-product row; no carries exist yet.
    assign sum_v[0] = pp[0];
    assign car_v[0] = '0;

    generate
        for (genvar j = 1; j < Y_W; j++) begin : g_row
            for (genvar i = 0; i < X_W; i++) begin : g_col
                logic    b_in;
                cs_bit_t cell_out;

                if (i < X_W - 1) begin : g_inner
                    // Previous row's sum one column up has weight j+i here.
                    assign b_in = sum_v[j-1][i+1];
                end else begin : g_edge
                    // Nothing sits above the top column of the array.
                    assign b_in = 1'b0;
                end

                csa_cell #(.FULL(j > 1)) u_cell (
                    .a   (pp[j][i]),
                    .b   (b_in),
                    .cin (car_v[j-1][i]),
                    .res (cell_out)
                );

                assign sum_v[j][i] = cell_out.sum;
                assign car_v[j][i] = cell_out.carry;
            end
        end

        for (genvar j = 0; j < Y_W; j++) begin : g_low
            // Column 0 of row j is final: it becomes product bit j.
            assign low_bits[j] = sum_v[j][0];
        end
    endgenerate

    // What is left after the last row goes to the merging adder.
    assign sum_rem = sum_v[LAST][X_W-1:1];
    assign car_rem = car_v[LAST];

endmodule

// File: rtl/csa_merge.sv
// Module: csa_merge
// Vector-merging ripple adder. It joins the remaining sum vector (one bit
// shorter) with the carry vector, using a carry input of 0.
// Assumes: X_W >= 2. carry_out is zero for any real product.
module csa_merge
    import csa_mult_pkg::*;
#(
    parameter int X_W = 4
) (
    input  logic [X_W-2:0] sum_rem,
    input  logic [X_W-1:0] car_rem,
    output logic [X_W-1:0] hi_bits,
    output logic           carry_out
);

    logic [X_W:0] chain;

    // The ripple starts with no carry.
    assign chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < X_W; i++) begin : g_bit
            logic    a_in;
            cs_bit_t cell_out;

            if (i < X_W - 1) begin : g_sum
                // Sum bit of the same weight from the array.
                assign a_in = sum_rem[i];
            end else begin : g_pad
                // The sum vector has no bit at the top weight.
                assign a_in = 1'b0;
            end

            csa_cell #(.FULL(1'b1)) u_cell (
                .a   (a_in),
                .b   (car_rem[i]),
                .cin (chain[i]),
                .res (cell_out)
            );

            assign hi_bits[i]  = cell_out.sum;
            assign chain[i+1]  = cell_out.carry;
        end
    endgenerate

    assign carry_out = chain[X_W];

endmodule

// File: rtl/csa_mult.sv
// Module: csa_mult (top)
// Unsigned X_W x Y_W carry-save array multiplier with a registered product.
// Both operands are fanned out to the whole array. The low Y_W product bits
// come from the array rows and the high X_W bits from the merging adder.
// Assumes: X_W >= 2, Y_W >= 2. Reset is synchronous and active low.
module csa_mult #(
    parameter int X_W = 4,
    parameter int Y_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [X_W-1:0]     x_in,
    input  logic [Y_W-1:0]     y_in,
    output logic [X_W+Y_W-1:0] z_out
);

    localparam int P_W = X_W + Y_W;

    logic [Y_W-1:0][X_W-1:0] pp;
    logic [Y_W-1:0]          low_bits;
    logic [X_W-2:0]          sum_rem;
    logic [X_W-1:0]          car_rem;
    logic [X_W-1:0]          hi_bits;
    logic                    merge_ovf;
    logic [P_W-1:0]          prod_c;

    csa_pp_gen #(.X_W(X_W), .Y_W(Y_W)) u_pp (
        .x_op (x_in),
        .y_op (y_in),
        .pp   (pp)
    );

    csa_array #(.X_W(X_W), .Y_W(Y_W)) u_array (
        .pp       (pp),
        .low_bits (low_bits),
        .sum_rem  (sum_rem),
        .car_rem  (car_rem)
    );

    csa_merge #(.X_W(X_W)) u_merge (
        .sum_rem   (sum_rem),
        .car_rem   (car_rem),
        .hi_bits   (hi_bits),
        .carry_out (merge_ovf)
    );

    // Product word: merged high bits above the row-by-row low bits.
    assign prod_c = {hi_bits, low_bits};

    // Capture the product; a low rst_n clears it at the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_out <= '0;
        end else begin
            z_out <= prod_c;
        end
    end

endmodule

// File: rtl/csa_mult_chk.sv
// Module: csa_mult_chk
// Assertion checker for csa_mult, attached with bind below. It compares the
// internal row outputs and the registered product with a reference multiply.
// Assumes: operands are known at every sampled edge.
module csa_mult_chk #(
    parameter int X_W = 4,
    parameter int Y_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [X_W-1:0]     x_in,
    input logic [Y_W-1:0]     y_in,
    input logic [X_W+Y_W-1:0] z_out,
    input logic [Y_W-1:0]     low_bits,
    input logic               merge_ovf
);

    localparam int P_W = X_W + Y_W;

    logic [P_W-1:0] ref_prod;
    assign ref_prod = P_W'(x_in) * P_W'(y_in);

    // R1: registered product equals the previous operands' product.
    assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (z_out == $past(ref_prod)));

    // R3: one low bit per row equals the low part of the product.
    assert_low_rows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        low_bits == ref_prod[Y_W-1:0]);

    // R4: the merging adder never carries beyond the product width.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !merge_ovf);

    // R5: reset at an edge clears the output.
    assert_reset_clear_R5: assert property (@(posedge clk)
        !rst_n |=> (z_out == '0));

    // R6: a zero operand yields a zero product.
    assert_zero_operand_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((x_in == '0) || (y_in == '0)) |=> (z_out == '0));

endmodule

bind csa_mult csa_mult_chk #(.X_W(X_W), .Y_W(Y_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .x_in      (x_in),
    .y_in      (y_in),
    .z_out     (z_out),
    .low_bits  (low_bits),
    .merge_ovf (merge_ovf)
);

// File: tb/csa_mult_test.sv
// Bench for csa_mult: a driver task pushes expected products into a
// scoreboard queue, and a monitor pops and compares after each edge.
module csa_mult_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tb_x = 4'd15;
    logic [3:0] tb_y = 4'd15;
    logic [7:0] tb_z;
    logic [5:0] wx = 6'd0;
    logic [3:0] wy = 4'd0;
    logic [9:0] wz;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    csa_mult uut (
        .clk (clk), .rst_n (rst_n), .x_in (tb_x), .y_in (tb_y), .z_out (tb_z)
    );

    csa_mult #(.X_W(6), .Y_W(4)) uut_wide (
        .clk (clk), .rst_n (rst_n), .x_in (wx), .y_in (wy), .z_out (wz)
    );

    task automatic check(input int actual, input int expected, input string req);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Driver: present operands at a falling edge and push the expected product.
    task automatic drive(input int xv, input int yv, input string req);
        tb_x = 4'(xv);
        tb_y = 4'(yv);
        exp_q.push_back(8'(xv * yv));
        tag_q.push_back(req);
        @(negedge clk);
    endtask

    // Monitor: just after each rising edge, compare with the oldest item.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      t = tag_q.pop_front();
            check(int'(tb_z), int'(e), t);
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R5: reset held with nonzero operands keeps the output at 0.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(int'(tb_z), 0, "R5 reset state");
        check(int'(wz), 0, "R5 reset state wide");
        rst_n = 1'b1;

        // R1 and R6: every operand pair at 4x4.
        for (int xa = 0; xa < 16; xa++) begin
            for (int ya = 0; ya < 16; ya++) begin
                drive(xa, ya, (xa == 0 || ya == 0) ? "R6" : "R1");
            end
        end

        // R2: single-bit operands place one bit at weight i+j.
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                drive(1 << i, 1 << j, "R2");
            end
        end

        // R3: low bits out of the rows (63 -> low nibble 15, 143 -> 15).
        drive(7, 9, "R3");
        drive(13, 11, "R3");
        // R4: top product bit set, no carry lost in the merge.
        drive(15, 9, "R4");
        drive(12, 15, "R4");
        // R7: all ones.
        drive(15, 15, "R7");

        // R5: reset in mid-run overrides live operands.
        @(posedge clk);
        #2;
        check(int'(tb_z), 225, "R7 hold before reset");
        @(negedge clk);
        rst_n = 1'b0;
        tb_x  = 4'd15;
        tb_y  = 4'd13;
        @(negedge clk);
        check(int'(tb_z), 0, "R5 mid-run reset");
        @(negedge clk);
        check(int'(tb_z), 0, "R5 reset held");
        rst_n = 1'b1;
        drive(15, 13, "R1 after reset");
        drive(0, 9, "R6");

        // R8: 6x4 instance, worked case and extreme case.
        wx = 6'd42;
        wy = 4'd11;
        @(negedge clk);
        check(int'(wz), 462, "R8 42x11");
        wx = 6'd63;
        wy = 4'd15;
        @(negedge clk);
        check(int'(wz), 945, "R8 63x15");

        repeat (3) @(negedge clk);
        check(exp_q.size(), 0, "R1 scoreboard drained");
        summary();
        $finish;
    end

endmodule